// File: doc/BRIEF.md
# Buffered Program Command Loader

This block sits behind a bus write port and takes in a buffered-program command sequence. Two unlock writes open the sequence. A load command written inside a block names the target block, and the next write gives the word count minus one. Up to 32 address/data pairs then fill a small page buffer, in any order within one 32-word page. A final confirm command commits the buffer, and the block then hands the stored words to the programming engine as a stream of program requests.

Every step is validated. The checks cover the word count, the page membership of each pair, repeated loads of one location, the number of pairs and the exact confirm command. Any violation abandons the whole operation. The abort flag then stays up and no request is issued until a reset command is written. While the buffer is being emitted the block reports busy and ignores writes.

Top module: `wbuf_prog_loader`

## Requirements
- R1: After a synchronous reset, busy, abort_flag and prog_valid are all 0.
- R2: A sequence opens only with data 0x00AA at address 0x000555, then data 0x0055 at address 0x000AAA. The third write must carry data 0x0025, and its address bits 23:16 select the block. The fourth write's data is the word count minus one. A wrong write in either unlock step returns the block to idle without aborting.
- R3: A count value greater than 31 (0x1F) aborts. A value of 31 is accepted and loads 32 words.
- R4: The first pair fixes the page as address bits 23:5. A later pair whose bits 23:5 differ aborts.
- R5: Pairs may arrive in any offset order (address bits 4:0). A second pair at an offset already loaded aborts.
- R6: After exactly count+1 pairs, the next write must be data 0x0029 at the block base address (block bits 23:16, low 16 bits zero). Any other write aborts, including an extra pair, another address or other data.
- R7: If data 0x0029 at the block base address arrives before count+1 pairs have been loaded, the operation aborts.
- R8: On commit, one word per cycle is issued in ascending offset order, with prog_addr = {page, offset} and prog_data = the stored word. The first prog_valid appears in the second cycle after the confirm write is sampled. busy is high from the cycle after the confirm through the last prog_valid cycle, and writes sampled while busy are ignored.
- R9: While aborted, abort_flag stays 1 and no program request is issued. Only a write with data 0x00F0, at any address, clears it and returns the block to idle.
- R10: A write with data 0x00F0 during the unlock, command or count steps returns the block to idle with abort_flag left at 0.
- R11: After the last word of a commit, the block is idle with abort_flag 0 and accepts a new sequence at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | 24 | Bus write address |
| wr_data | input | 16 | Bus write data |
| busy | output | 1 | Commit in progress |
| abort_flag | output | 1 | Operation aborted, held until reset command |
| prog_valid | output | 1 | A program request is present this cycle |
| prog_addr | output | 24 | Word address of the program request |
| prog_data | output | 16 | Word to program |

## Verification
The hardest situation to reach is the cycle that ends a commit. The last request is still on the outputs while the control has already gone idle, and any write sampled then must still be dropped. The stimulus fills the whole 32-word buffer in descending order and then writes an unlock pair right behind the confirm, so these writes fall inside the busy window. A complete loading sequence follows that would only emit if those writes had been taken. A behavioural model with a queue of expected requests is compared against every output on every clock. As a result, every abort path, from a bad count, a foreign page, a duplicate, an early confirm or a wrong confirm, is checked in the exact cycle it takes effect.

// File: rtl/wbpl_pkg.sv
package wbpl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_CNT, ST_LOAD, ST_CONF, ST_EMIT, ST_ABORT
  } wbpl_state_e;

  localparam logic [15:0] CMD_UNL1 = 16'h00AA;
  localparam logic [15:0] CMD_UNL2 = 16'h0055;
  localparam logic [15:0] CMD_LOAD = 16'h0025;
  localparam logic [15:0] CMD_CONF = 16'h0029;
  localparam logic [15:0] CMD_RST  = 16'h00F0;
endpackage

// File: rtl/wbpl_pick.sv
module wbpl_pick #(
  parameter int WIDTH = 32,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] mask,
  output logic [IDX_W-1:0] idx
);
  logic [WIDTH-1:0] iso;
  assign iso = mask & (~mask + WIDTH'(1));

  function automatic logic [WIDTH-1:0] sel_of(input int b);
    logic [WIDTH-1:0] s;
    for (int i = 0; i < WIDTH; i++) s[i] = ((i >> b) & 1) == 1;
    return s;
  endfunction

  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    assign idx[b] = |(iso & sel_of(b));
  end
endmodule

// File: rtl/wbpl_buf.sv
module wbpl_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wbpl_seq.sv
module wbpl_seq
  import wbpl_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DATA_W    = 16,
  parameter int          BUF_WORDS = 32,
  parameter int          BLK_LSB   = 16,
  parameter logic [23:0] UNL_A1    = 24'h000555,
  parameter logic [23:0] UNL_A2    = 24'h000AAA,
  parameter int          OFF_W     = $clog2(BUF_WORDS),
  parameter int          PAGE_W    = ADDR_W - OFF_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [OFF_W-1:0]     pick_idx,
  output logic [BUF_WORDS-1:0] mask,
  output logic                 emit_en,
  output logic                 ld_we,
  output logic [OFF_W-1:0]     ld_off,
  output logic [PAGE_W-1:0]    page,
  output logic                 aborted
);
  localparam int BLK_W = ADDR_W - BLK_LSB;

  wbpl_state_e          state_q, nxt;
  logic [BLK_W-1:0]     blk_q;
  logic [PAGE_W-1:0]    page_q;
  logic [OFF_W-1:0]     count_q, loaded_q;
  logic [BUF_WORDS-1:0] mask_q, pick_bit;
  logic                 is_conf, in_page, pair_ok, last_pair, is_rst;

  always_comb begin
    ld_off    = wr_addr[OFF_W-1:0];
    is_rst    = wr_data == DATA_W'(CMD_RST);
    is_conf   = (wr_data == DATA_W'(CMD_CONF)) &&
                (wr_addr == {blk_q, {BLK_LSB{1'b0}}});
    in_page   = (loaded_q == '0) || (wr_addr[ADDR_W-1:OFF_W] == page_q);
    pair_ok   = wr_en && (state_q == ST_LOAD) && !is_conf && in_page &&
                !mask_q[ld_off];
    last_pair = loaded_q == count_q;
    pick_bit  = BUF_WORDS'(1) << pick_idx;
  end

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_IDLE:  if (wr_en && wr_addr == ADDR_W'(UNL_A1) &&
                    wr_data == DATA_W'(CMD_UNL1)) nxt = ST_UNL1;
      ST_UNL1:  if (wr_en) nxt = (wr_addr == ADDR_W'(UNL_A2) &&
                    wr_data == DATA_W'(CMD_UNL2)) ? ST_UNL2 : ST_IDLE;
      ST_UNL2:  if (wr_en) nxt = (wr_data == DATA_W'(CMD_LOAD)) ? ST_CNT : ST_IDLE;
      ST_CNT:   if (wr_en) nxt = is_rst ? ST_IDLE :
                    (wr_data > DATA_W'(BUF_WORDS - 1)) ? ST_ABORT : ST_LOAD;
      ST_LOAD:  if (wr_en) nxt = !pair_ok ? ST_ABORT : last_pair ? ST_CONF : ST_LOAD;
      ST_CONF:  if (wr_en) nxt = is_conf ? ST_EMIT : ST_ABORT;
      ST_EMIT:  if ((mask_q & ~pick_bit) == '0) nxt = ST_IDLE;
      default:  if (wr_en && is_rst) nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      loaded_q <= '0;
      count_q  <= '0;
      blk_q    <= '0;
      page_q   <= '0;
    end else begin
      state_q <= nxt;
      if (wr_en && state_q == ST_UNL2) blk_q <= wr_addr[ADDR_W-1:BLK_LSB];
      if (wr_en && state_q == ST_CNT && nxt == ST_LOAD) begin
        count_q  <= wr_data[OFF_W-1:0];
        loaded_q <= '0;
        mask_q   <= '0;
      end
      if (pair_ok) begin
        mask_q[ld_off] <= 1'b1;
        loaded_q       <= loaded_q + 1'b1;
        if (loaded_q == '0) page_q <= wr_addr[ADDR_W-1:OFF_W];
      end
      if (state_q == ST_EMIT) mask_q <= mask_q & ~pick_bit;
    end
  end

  assign mask    = mask_q;
  assign emit_en = state_q == ST_EMIT;
  assign ld_we   = pair_ok;
  assign page    = page_q;
  assign aborted = state_q == ST_ABORT;

  assert_full_count_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONF) |-> ($countones(mask_q) == int'(count_q) + 1));
  assert_load_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD) |-> (loaded_q <= count_q));
  assert_abort_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ABORT && !(wr_en && is_rst)) |=> (state_q == ST_ABORT));
  assert_emit_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EMIT) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
endmodule

// File: rtl/wbuf_prog_loader.sv
module wbuf_prog_loader #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int BUF_WORDS = 32,
  parameter int BLK_LSB   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              abort_flag,
  output logic              prog_valid,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);
  localparam int OFF_W  = $clog2(BUF_WORDS);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [BUF_WORDS-1:0] mask;
  logic [OFF_W-1:0]     pick_idx, ld_off;
  logic [PAGE_W-1:0]    page;
  logic                 emit_en, ld_we, wr_go, valid_q;
  logic [ADDR_W-1:0]    addr_q;

  assign wr_go = wr_en && !valid_q;

  wbpl_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS), .BLK_LSB(BLK_LSB)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_go), .wr_addr(wr_addr), .wr_data(wr_data),
    .pick_idx(pick_idx), .mask(mask), .emit_en(emit_en), .ld_we(ld_we),
    .ld_off(ld_off), .page(page), .aborted(abort_flag)
  );

  wbpl_pick #(.WIDTH(BUF_WORDS), .IDX_W(OFF_W)) u_pick (
    .mask(mask), .idx(pick_idx)
  );

  wbpl_buf #(.DATA_W(DATA_W), .DEPTH(BUF_WORDS), .IDX_W(OFF_W)) u_buf (
    .clk(clk), .we(ld_we), .waddr(ld_off), .wdata(wr_data),
    .re(emit_en), .raddr(pick_idx), .rdata(prog_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= emit_en;
      if (emit_en) addr_q <= {page, pick_idx};
    end
  end

  assign prog_valid = valid_q;
  assign prog_addr  = addr_q;
  assign busy       = emit_en || valid_q;

  assert_ascend_R8: assert property (@(posedge clk) disable iff (rst)
    (prog_valid && $past(prog_valid)) |->
      (prog_addr[OFF_W-1:0] > $past(prog_addr[OFF_W-1:0])));
  assert_one_page_R4: assert property (@(posedge clk) disable iff (rst)
    (prog_valid && $past(prog_valid)) |->
      (prog_addr[ADDR_W-1:OFF_W] == $past(prog_addr[ADDR_W-1:OFF_W])));
  assert_quiet_abort_R9: assert property (@(posedge clk) disable iff (rst)
    abort_flag |-> (!prog_valid && !busy));
  assert_valid_busy_R8: assert property (@(posedge clk) disable iff (rst)
    prog_valid |-> busy);
endmodule

// File: tb/wbuf_prog_loader_test.sv
module wbuf_prog_loader_test;
  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  wire         busy, abort_flag, prog_valid;
  wire  [23:0] prog_addr;
  wire  [15:0] prog_data;

  int checks = 0, errors = 0, nvalid = 0;

  wbuf_prog_loader uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .abort_flag(abort_flag), .prog_valid(prog_valid),
    .prog_addr(prog_addr), .prog_data(prog_data)
  );

  always #4 clk = ~clk;

  // reference model: 0 idle,1 unl1,2 unl2,3 count,4 load,5 confirm,6 abort,7 emit,8 drain
  int ph = 0, m_cnt, m_loaded, m_page, m_blk, e_addr, e_data;
  bit e_valid = 0;
  bit m_seen[32];
  int m_buf[32];
  int qa[$], qd[$];

  function automatic void model_write(int a, int d);
    case (ph)
      0: if (a == 'h555 && d == 'hAA) ph = 1;
      1: ph = (a == 'hAAA && d == 'h55) ? 2 : 0;
      2: begin ph = (d == 'h25) ? 3 : 0; m_blk = a >> 16; end
      3: if (d == 'hF0) ph = 0;
         else if (d > 31) ph = 6;
         else begin
           m_cnt = d; m_loaded = 0; ph = 4;
           for (int i = 0; i < 32; i++) m_seen[i] = 0;
         end
      4: if (d == 'h29 && a == (m_blk << 16)) ph = 6;
         else if (m_loaded > 0 && (a >> 5) != m_page) ph = 6;
         else if (m_seen[a & 31]) ph = 6;
         else begin
           if (m_loaded == 0) m_page = a >> 5;
           m_seen[a & 31] = 1; m_buf[a & 31] = d; m_loaded++;
           if (m_loaded == m_cnt + 1) ph = 5;
         end
      5: if (d == 'h29 && a == (m_blk << 16)) begin
           for (int i = 0; i < 32; i++)
             if (m_seen[i]) begin qa.push_back(m_page * 32 + i); qd.push_back(m_buf[i]); end
           ph = 7;
         end else ph = 6;
      6: if (d == 'hF0) ph = 0;
      default: ;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; e_valid = 0; qa.delete(); qd.delete();
    end else begin
      e_valid = 0;
      case (ph)
        7: begin
          e_addr = qa.pop_front(); e_data = qd.pop_front(); e_valid = 1;
          if (qa.size() == 0) ph = 8;
        end
        8: ph = 0;
        default: if (wr_en) model_write(int'(wr_addr), int'(wr_data));
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    check(busy == (ph == 7 || ph == 8), "R8 busy per cycle", busy, (ph == 7 || ph == 8));
    check(abort_flag == (ph == 6), "R9 abort per cycle", abort_flag, ph == 6);
    check(prog_valid == e_valid, "R8 prog_valid per cycle", prog_valid, e_valid);
    if (e_valid && prog_valid) begin
      check(int'(prog_addr) == e_addr, "R8 prog_addr", prog_addr, e_addr);
      check(int'(prog_data) == e_data, "R8 prog_data", prog_data, e_data);
    end
    if (prog_valid) nvalid++;
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 24'(a); wr_data = 16'(d);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic hdr(input int blk, input int cnt);
    wr('h555, 'hAA); wr('hAAA, 'h55); wr(blk << 16, 'h25); wr(blk << 16, cnt);
  endtask

  task automatic flag_is(input bit exp, input string tag);
    idle(2);
    check(abort_flag == exp, tag, abort_flag, exp);
  endtask

  task automatic clear_abort();
    wr('h000000, 'hF0);
    flag_is(0, "R9 reset command clears abort");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(abort_flag == 0, "R1 abort after reset", abort_flag, 0);
    check(prog_valid == 0, "R1 valid after reset", prog_valid, 0);
    rst = 1'b0;
    idle(2);

    // R8/R11: four words loaded out of order
    base = nvalid;
    hdr('h12, 3);
    wr('h1234A7, 'hBEEF); wr('h1234A2, 'h1111); wr('h1234BF, 'h2222); wr('h1234A0, 'h3333);
    wr('h120000, 'h29);
    idle(10);
    check(nvalid - base == 4, "R8 four requests issued", nvalid - base, 4);
    check(abort_flag == 0 && busy == 0, "R11 idle after commit", {busy, abort_flag}, 0);

    // R3: count too large, then R9 stickiness
    base = nvalid;
    hdr('h12, 'h20);
    flag_is(1, "R3 count 0x20 aborts");
    wr('h120000, 'h29); wr('h555, 'hAA);
    flag_is(1, "R9 abort holds on other writes");
    check(nvalid == base, "R9 no request while aborted", nvalid - base, 0);
    clear_abort();

    // R4: foreign page
    hdr('h12, 2); wr('h1234A1, 1); wr('h123481, 2);
    flag_is(1, "R4 page mismatch aborts");
    clear_abort();

    // R5: duplicate offset
    hdr('h12, 2); wr('h1234A3, 1); wr('h1234A3, 2);
    flag_is(1, "R5 duplicate load aborts");
    clear_abort();

    // R6: extra pair instead of confirm
    hdr('h12, 1); wr('h1234A1, 1); wr('h1234A2, 2); wr('h1234A4, 5);
    flag_is(1, "R6 extra pair aborts");
    clear_abort();
    // R6: confirm at wrong address
    hdr('h12, 0); wr('h1234A1, 1); wr('h120001, 'h29);
    flag_is(1, "R6 confirm off base aborts");
    clear_abort();
    // R6: wrong confirm data
    hdr('h12, 0); wr('h1234A1, 1); wr('h120000, 'h28);
    flag_is(1, "R6 wrong confirm data aborts");
    clear_abort();

    // R7: early confirm
    hdr('h12, 2); wr('h1234A1, 1); wr('h120000, 'h29);
    flag_is(1, "R7 early confirm aborts");
    clear_abort();

    // R10: reset command mid-sequence
    wr('h555, 'hAA); wr('hAAA, 'h55); wr('h120000, 'hF0);
    flag_is(0, "R10 reset in unlock step");
    wr('h555, 'hAA); wr('hAAA, 'h55); wr('h120000, 'h25); wr('h120000, 'hF0);
    flag_is(0, "R10 reset in count step");

    // R2: broken unlock returns idle, later writes do not start a load
    base = nvalid;
    wr('h555, 'hAA); wr('hAAA, 'h12);
    wr('h120000, 'h25); wr('h120000, 0); wr('h1234A0, 5); wr('h120000, 'h29);
    idle(6);
    check(abort_flag == 0, "R2 bad unlock no abort", abort_flag, 0);
    check(nvalid == base, "R2 bad unlock no requests", nvalid - base, 0);

    // R8/R3: full 32-word buffer, descending order, writes during busy ignored
    base = nvalid;
    hdr('h3F, 31);
    for (int i = 31; i >= 0; i--) wr('h3F0040 + i, (i * 'h101) ^ 'hA5A5);
    wr('h3F0000, 'h29);
    wr('h555, 'hAA); wr('hAAA, 'h55);
    idle(40);
    wr('h3F0000, 'h25); wr('h3F0000, 0); wr('h3F0047, 7); wr('h3F0000, 'h29);
    idle(6);
    check(nvalid - base == 32, "R8 full buffer, busy writes ignored", nvalid - base, 32);
    check(abort_flag == 0, "R3 count 31 accepted", abort_flag, 0);

    // R11: single-word operation right after
    base = nvalid;
    hdr('h3F, 0); wr('h3F0005, 'h77); wr('h3F0000, 'h29);
    idle(6);
    check(nvalid - base == 1, "R11 next operation accepted", nvalid - base, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule